// File: doc/BRIEF.md
# Host Descriptor Queue Consumer

This block is the device-side engine of a circular control queue in shared memory. Only the host writes the queue. The host writes an entry with its valid bit set, advances its own write index, and the interconnect reports the write to this block on a snoop strobe. Each snoop earns one fetch attempt. The block reads the entry at its private read index and checks the valid bit to see whether the device owns the entry. If it does, the block hands the payload to a downstream processing port, writes the entry back with the valid bit cleared, and advances the read index. The index wraps at the configured queue size.

The host must never overrun the device, but it does not poll the device's read index directly. Instead, after every configured number of consumed entries, the block writes its read index to a host-visible status word. The host treats the queue as full when its next write index would equal that status word, so one slot always stays unused.

A queue can be configured as a free-buffer queue. On such a queue, a fetch that finds an invalid entry means the host has run out of buffers. The block then enters a sticky underflow state and requests early packet discard for every channel fed by the queue. The state ends when a later fetch finds a valid entry. Memory is reached through a single request/acknowledge port with one transaction in flight.

Top module: `hostq_drain`

## Requirements
- R1: After reset, `memReq`, `outValid` and `discardReq` are low, and the first fetch reads address `cfgBase + 0`.
- R2: Each `snoopHit` pulse causes exactly one fetch attempt. Pulses that arrive while the block is busy are counted and served later. Every host entry is delivered exactly once.
- R3: Bit `ENTRY_W-1` of an entry is its valid bit. When a fetched entry has this bit at 1, its low `ENTRY_W-1` bits appear on `outData` with a single-cycle `outValid` pulse. Entries are delivered in host write order.
- R4: After delivering an entry, the block writes that entry back to the same address, with the valid bit at 0 and the payload unchanged. The read index then advances by one and returns to 0 after `cfgQueueSize-1`. The fetch address is `cfgBase + index`.
- R5: After every `cfgInterval` consumed entries, the block writes the already-advanced read index, zero-extended, to `cfgUdAddr`. The consumed-entry count then restarts from 0.
- R6: When `cfgFreeBuf` is 0, a fetch that finds the valid bit at 0 produces no output, no memory write and no discard request.
- R7: When `cfgFreeBuf` is 1, a fetch that finds the valid bit at 0 raises `discardReq`. The request stays high across further invalid fetches.
- R8: While `discardReq` is high, a fetch that finds a valid entry consumes it normally. `discardReq` falls in the cycle in which `outValid` pulses for that entry.
- R9: Only one memory transaction is in flight at a time, in the order: read the entry, then clear it, then (when due) write the status word. `memReq`, `memWe`, `memAddr` and `memWdata` stay stable until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgQueueSize | input | IDX_W+1 | Number of queue entries (2 .. 2**IDX_W) |
| cfgInterval | input | INT_W | Consumed entries between status writebacks (1 .. cfgQueueSize-1) |
| cfgFreeBuf | input | 1 | Queue holds free buffers; empty fetch is underflow |
| cfgBase | input | ADDR_W | Word address of queue entry 0 |
| cfgUdAddr | input | ADDR_W | Word address of host-visible read-index status word |
| snoopHit | input | 1 | One-cycle pulse per host write into the queue area |
| memReq | output | 1 | Memory transaction request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Word address of the transaction |
| memWdata | output | ENTRY_W | Write data |
| memAck | input | 1 | One-cycle completion of the current transaction |
| memRdata | input | ENTRY_W | Read data, valid with `memAck` on a read |
| outValid | output | 1 | One-cycle pulse: `outData` holds a consumed payload |
| outData | output | ENTRY_W-1 | Payload of the consumed entry |
| discardReq | output | 1 | Early packet discard request while the queue is in underflow |

## Verification
Two things can happen in the same clock edge. A fresh `snoopHit` can arrive in the very cycle in which the control takes a pending attempt, so the pending count must both rise and fall at that edge. The bench provokes this by issuing host writes back to back, and by adding stray snoops, while the block is still draining earlier entries under a memory that acknowledges after a random delay. A lost or doubled attempt is judged at the ports: every host payload must appear exactly once, in order. Each clear write must land at the predicted index, and each status write must carry the predicted value.

// File: rtl/hostq_pkg.sv
package hostq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CLEAR,
    ST_REPORT
  } drainState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takePend;   // consume one pending fetch attempt
    logic emitOut;    // capture payload and pulse the output
    logic advance;    // step read index and writeback counter
    logic setUnder;   // enter underflow state
    logic clrUnder;   // leave underflow state
    logic selUd;      // address/data select the status word
  } ctlStrobes_t;

endpackage

// File: rtl/hostq_datapath.sv
module hostq_datapath
  import hostq_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int ENTRY_W = 32,
  parameter int ADDR_W  = 16,
  parameter int INT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        stb,
  input  logic               snoopHit,
  input  logic [IDX_W:0]     cfgQueueSize,
  input  logic [INT_W-1:0]   cfgInterval,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [ADDR_W-1:0]  cfgUdAddr,
  input  logic [ENTRY_W-1:0] memRdata,
  output logic               entryValid,
  output logic               updDue,
  output logic               pendAny,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ENTRY_W-1:0] memWdata,
  output logic               outValid,
  output logic [ENTRY_W-2:0] outData,
  output logic               discardReq
);

  localparam int PEND_W  = IDX_W + 1;
  localparam int VLD_BIT = ENTRY_W - 1;
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [IDX_W-1:0]  readIdx;
  logic [IDX_W-1:0]  readIdxNext;
  logic [INT_W-1:0]  updCnt;
  logic [INT_W:0]    updCntInc;
  logic [PEND_W-1:0] pendCnt;
  logic              underflow;

  // ownership flag of the word being returned
  assign entryValid = memRdata[VLD_BIT];

  // read index wraps at configured size
  always_comb begin
    if (({1'b0, readIdx} + 1'b1) == cfgQueueSize) readIdxNext = '0;
    else                                          readIdxNext = readIdx + 1'b1;
  end

  assign updCntInc = {1'b0, updCnt} + 1'b1;
  assign updDue    = (updCntInc >= {1'b0, cfgInterval});
  assign pendAny   = (pendCnt != '0);

  // address and write data mux
  always_comb begin
    if (stb.selUd) begin
      memAddr  = cfgUdAddr;
      memWdata = ENTRY_W'(readIdx);
    end else begin
      memAddr  = cfgBase + ADDR_W'(readIdx);
      memWdata = {1'b0, outData};
    end
  end

  // pending fetch attempts, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCnt <= '0;
    end else begin
      case ({snoopHit, stb.takePend})
        2'b10:   if (pendCnt != PEND_MAX) pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // read index and writeback interval counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readIdx <= '0;
      updCnt  <= '0;
    end else if (stb.advance) begin
      readIdx <= readIdxNext;
      updCnt  <= updDue ? '0 : updCntInc[INT_W-1:0];
    end
  end

  // payload capture and output strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= stb.emitOut;
      if (stb.emitOut) outData <= memRdata[ENTRY_W-2:0];
    end
  end

  // sticky underflow state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            underflow <= 1'b0;
    else if (stb.setUnder) underflow <= 1'b1;
    else if (stb.clrUnder) underflow <= 1'b0;
  end

  assign discardReq = underflow;

endmodule

// File: rtl/hostq_ctrl.sv
module hostq_ctrl
  import hostq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgFreeBuf,
  input  logic        pendAny,
  input  logic        memAck,
  input  logic        entryValid,
  input  logic        updDue,
  output logic        memReq,
  output logic        memWe,
  output ctlStrobes_t stb
);

  drainState_t state;
  drainState_t stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pendAny) begin
          stb.takePend = 1'b1;
          stateNext    = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (entryValid) begin
            stb.emitOut  = 1'b1;
            stb.clrUnder = 1'b1;
            stateNext    = ST_CLEAR;
          end else begin
            stb.setUnder = cfgFreeBuf;
            stateNext    = ST_IDLE;
          end
        end
      end
      ST_CLEAR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          stb.advance = 1'b1;
          stateNext   = updDue ? ST_REPORT : ST_IDLE;
        end
      end
      ST_REPORT: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        stb.selUd = 1'b1;
        if (memAck) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/hostq_drain.sv
module hostq_drain
  import hostq_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int ENTRY_W = 32,
  parameter int ADDR_W  = 16,
  parameter int INT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W:0]     cfgQueueSize,
  input  logic [INT_W-1:0]   cfgInterval,
  input  logic               cfgFreeBuf,
  input  logic [ADDR_W-1:0]  cfgBase,
  input  logic [ADDR_W-1:0]  cfgUdAddr,
  input  logic               snoopHit,
  output logic               memReq,
  output logic               memWe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [ENTRY_W-1:0] memWdata,
  input  logic               memAck,
  input  logic [ENTRY_W-1:0] memRdata,
  output logic               outValid,
  output logic [ENTRY_W-2:0] outData,
  output logic               discardReq
);

  ctlStrobes_t stb;
  logic        entryValid;
  logic        updDue;
  logic        pendAny;

  hostq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgFreeBuf (cfgFreeBuf),
    .pendAny    (pendAny),
    .memAck     (memAck),
    .entryValid (entryValid),
    .updDue     (updDue),
    .memReq     (memReq),
    .memWe      (memWe),
    .stb        (stb)
  );

  hostq_datapath #(
    .IDX_W   (IDX_W),
    .ENTRY_W (ENTRY_W),
    .ADDR_W  (ADDR_W),
    .INT_W   (INT_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .stb          (stb),
    .snoopHit     (snoopHit),
    .cfgQueueSize (cfgQueueSize),
    .cfgInterval  (cfgInterval),
    .cfgBase      (cfgBase),
    .cfgUdAddr    (cfgUdAddr),
    .memRdata     (memRdata),
    .entryValid   (entryValid),
    .updDue       (updDue),
    .pendAny      (pendAny),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .outValid     (outValid),
    .outData      (outData),
    .discardReq   (discardReq)
  );

endmodule

// File: rtl/hostq_drain_chk.sv
module hostq_drain_chk #(
  parameter int ENTRY_W = 32,
  parameter int ADDR_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfgFreeBuf,
  input logic               memReq,
  input logic               memWe,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [ENTRY_W-1:0] memWdata,
  input logic               memAck,
  input logic               outValid,
  input logic               discardReq
);

  // R9: a waiting transaction holds still until acknowledged
  a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));

  // R4: every write leaves the valid bit at zero
  a_r4_write_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe) |-> !memWdata[ENTRY_W-1]);

  // R3: output is a single-cycle pulse
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> !outValid);

  // R6: no discard on a queue that is not a free-buffer queue
  a_r6_no_discard_nonfree: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgFreeBuf |-> !discardReq);

  // R7: discard only rises on a free-buffer queue
  a_r7_discard_rise_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(discardReq) |-> cfgFreeBuf);

  // R8: discard ends only together with a delivered entry
  a_r8_discard_fall_with_output: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(discardReq) |-> outValid);

endmodule

bind hostq_drain hostq_drain_chk #(
  .ENTRY_W (ENTRY_W),
  .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/hostq_drain_bench.sv
module hostq_drain_bench;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W   = 4;
  localparam int ENTRY_W = 32;
  localparam int ADDR_W  = 16;
  localparam int INT_W   = 4;
  localparam int BASE    = 8;
  localparam int UDA     = 40;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [IDX_W:0]     cfgQueueSize = 5'd8;
  logic [INT_W-1:0]   cfgInterval = 4'd1;
  logic               cfgFreeBuf = 1'b0;
  logic [ADDR_W-1:0]  cfgBase = ADDR_W'(BASE);
  logic [ADDR_W-1:0]  cfgUdAddr = ADDR_W'(UDA);
  logic               snoopHit = 1'b0;
  logic               memReq;
  logic               memWe;
  logic [ADDR_W-1:0]  memAddr;
  logic [ENTRY_W-1:0] memWdata;
  logic               memAck = 1'b0;
  logic [ENTRY_W-1:0] memRdata = '0;
  logic               outValid;
  logic [ENTRY_W-2:0] outData;
  logic               discardReq;

  hostq_drain #(
    .IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .ADDR_W(ADDR_W), .INT_W(INT_W)
  ) u_hostq_drain (
    .clk(clk), .rst_n(rst_n), .cfgQueueSize(cfgQueueSize), .cfgInterval(cfgInterval),
    .cfgFreeBuf(cfgFreeBuf), .cfgBase(cfgBase), .cfgUdAddr(cfgUdAddr), .snoopHit(snoopHit),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata), .outValid(outValid), .outData(outData),
    .discardReq(discardReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [ENTRY_W-1:0] mem [0:63];
  logic [ENTRY_W-2:0] hostLog [0:255];
  int hostCount, outCount, clearCount, udWrites, writePtr, waitCnt;
  bit udOwed;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expIdx(input int consumed, input int size);
    return consumed % size;
  endfunction

  // memory model with random acknowledge latency, plus transaction checks
  always @(negedge clk) begin
    if (!rst_n) begin
      memAck = 1'b0;
      waitCnt = 0;
    end else if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        memAck = 1'b1;
        waitCnt = $urandom_range(0, 2);
        if (!memWe) begin
          check(!udOwed, "R9 status write precedes next fetch", udOwed, 0);
          check(memAddr == ADDR_W'(BASE + expIdx(clearCount, int'(cfgQueueSize))),
                "R4 fetch address", memAddr, BASE + expIdx(clearCount, int'(cfgQueueSize)));
          memRdata = mem[memAddr[5:0]];
        end else if (memAddr == ADDR_W'(UDA)) begin
          check(udOwed, "R5 status write only when due", udOwed, 1);
          check(memWdata == ENTRY_W'(expIdx(clearCount, int'(cfgQueueSize))),
                "R5 status value", memWdata, expIdx(clearCount, int'(cfgQueueSize)));
          udOwed = 1'b0;
          udWrites++;
          mem[memAddr[5:0]] = memWdata;
        end else begin
          check(memAddr == ADDR_W'(BASE + expIdx(clearCount, int'(cfgQueueSize))),
                "R4 clear address", memAddr, BASE + expIdx(clearCount, int'(cfgQueueSize)));
          check(memWdata == {1'b0, hostLog[clearCount[7:0]]},
                "R4 clear data", memWdata, {1'b0, hostLog[clearCount[7:0]]});
          mem[memAddr[5:0]] = memWdata;
          clearCount++;
          if (clearCount % int'(cfgInterval) == 0) udOwed = 1'b1;
        end
      end
    end
  end

  // output scoreboard
  always @(negedge clk) begin
    if (rst_n && outValid) begin
      check(outData == hostLog[outCount[7:0]], "R3 payload order", outData, hostLog[outCount[7:0]]);
      outCount++;
    end
  end

  task automatic snoop();
    @(negedge clk) snoopHit = 1'b1;
    @(negedge clk) snoopHit = 1'b0;
  endtask

  task automatic hostWrite();
    logic [ENTRY_W-2:0] pay;
    while (((writePtr + 1) % int'(cfgQueueSize)) == int'(mem[UDA])) @(negedge clk);
    pay = ENTRY_W'($urandom) & {(ENTRY_W-1){1'b1}};
    hostLog[hostCount[7:0]] = pay;
    hostCount++;
    mem[BASE + writePtr] = {1'b1, pay};
    writePtr = (writePtr + 1) % int'(cfgQueueSize);
    snoop();
  endtask

  task automatic phaseReset(input int size, input int intv, input bit freeBuf);
    @(negedge clk);
    rst_n = 1'b0;
    cfgQueueSize = (IDX_W+1)'(size);
    cfgInterval  = INT_W'(intv);
    cfgFreeBuf   = freeBuf;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    hostCount = 0; outCount = 0; clearCount = 0; udWrites = 0; writePtr = 0; udOwed = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!memReq && !outValid && !discardReq, "R1 reset outputs idle",
          {memReq, outValid, discardReq}, 0);
  endtask

  task automatic drain();
    while (outCount != hostCount) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic randomPhase(input int size, input int intv, input int n, input int maxGap, input bit stray);
    phaseReset(size, intv, 1'b0);
    for (int k = 0; k < n; k++) begin
      hostWrite();
      if (stray && ($urandom_range(0, 5) == 0)) snoop();
      repeat ($urandom_range(0, maxGap)) @(negedge clk);
    end
    drain();
    check(outCount == hostCount, "R2 each entry delivered once", outCount, hostCount);
    check(clearCount == hostCount, "R4 each entry cleared once", clearCount, hostCount);
    check(udWrites == hostCount / intv, "R5 status write count", udWrites, hostCount / intv);
    check(!discardReq, "R6 no discard on non-free queue", discardReq, 0);
  endtask

  initial begin
    void'($urandom(32'd20240917));
    repeat (2) @(negedge clk);

    randomPhase(8, 3, 40, 6, 1'b1);
    // R6: stray snoop on empty non-free queue changes nothing
    begin
      int oc, cc;
      oc = outCount; cc = clearCount;
      snoop();
      repeat (30) @(negedge clk);
      check(outCount == oc, "R6 no output on empty fetch", outCount, oc);
      check(clearCount == cc, "R6 no write on empty fetch", clearCount, cc);
      check(!discardReq, "R6 discard stays low", discardReq, 0);
    end

    randomPhase(5, 1, 30, 0, 1'b0);   // back-to-back snoops, wrap
    randomPhase(16, 15, 50, 3, 1'b1); // full-size queue, long interval
    randomPhase(2, 1, 12, 2, 1'b0);   // smallest queue

    // free-buffer queue: underflow entry and exit
    phaseReset(4, 2, 1'b1);
    hostWrite();
    hostWrite();
    drain();
    check(!discardReq, "R7 no discard while supplied", discardReq, 0);
    snoop();
    repeat (30) @(negedge clk);
    check(discardReq, "R7 discard on empty free-buffer fetch", discardReq, 1);
    check(outCount == 2, "R7 no output on underflow", outCount, 2);
    snoop();
    repeat (30) @(negedge clk);
    check(discardReq, "R7 discard sticky on repeated empty fetch", discardReq, 1);
    check(clearCount == 2, "R7 no clear write on underflow", clearCount, 2);
    hostWrite();
    drain();
    check(outCount == 3, "R8 entry consumed out of underflow", outCount, 3);
    check(!discardReq, "R8 discard released", discardReq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule